// File: doc/BRIEF.md
# Three-Phase Sine Duty Calculator

Once per PWM period this block turns a rotating voltage vector into three phase high-times for a downstream edge generator. Each `period_tick` advances a 32-bit angle accumulator by a programmed step. The block then evaluates the cosine of the angle and of the angle less 120 degrees, and takes the third phase value as the negated sum of the first two. Each phase value is scaled by the amplitude and converted into a high-time within the programmed period. The cosine comes from a host-loaded quarter-wave table of 32 entries, with quadrant mirroring and linear interpolation between adjacent entries.

The host writes amplitude, angle step, absolute angle, period and reload prescaler into shadow registers. It then writes a load code. Every `prescaler` periods a reload window opens. If a load code is pending at that point, the shadow values become active, the load code is cleared and an optional interrupt pulse is raised. Until the first reload the block runs with zero amplitude, which gives 50 % duty.

A control state machine sequences each period. Its states are IDLE, ADVANCE, COS_A, COS_B and SCALE, with these transitions:

- IDLE→ADVANCE when a period tick is seen.
- ADVANCE→COS_A, where the reload and the angle update take place.
- COS_A→COS_B, where phase A's cosine is captured.
- COS_B→SCALE, where phase B's cosine is captured.
- SCALE→IDLE, where the high-times are registered and `ht_valid` is pulsed.

Top module: `sine_duty_calc`

## Requirements
- R1: After reset, `ht_a`, `ht_b`, `ht_c`, `ht_valid`, `irq`, `load_pending` and `angle_out` are all zero.
- R2: A `period_tick` sampled in IDLE starts one computation. `ht_valid` is high for exactly one cycle, beginning at the fourth rising edge after the sampling edge. Ticks seen while a computation runs are ignored.
- R3: In each computed period the angle accumulator gains the active step, modulo 2^32, and `angle_out` shows the new angle.
- R4: The cosine of angle a (32 bits) is defined as follows. Quadrant q = a[31:30] and p = a[29:0]. Take x = p when a[30] is 0, and x = 2^30 − p otherwise. If x = 2^30 the magnitude is 0. Otherwise i = x[29:25] and f = x[24:9], and the magnitude is t[i] + floor((t[i+1] − t[i])·f / 2^16), with t[32] = 0. The result is negated when q is 1 or 2.
- R5: The phase A value is cos(angle), the phase B value is cos(angle − 0x55555555), and the phase C value is −(A + B).
- R6: For each phase value s: u = floor(Ampl·s / 2^16) + 32768, and ht = floor(T·u / 2^16) clamped to 0..T.
- R7: Before the first reload, amplitude is 0, step is 0, prescaler is 1 and T = RESET_PERIOD, so every high-time is floor(T/2).
- R8: Register map (word address): 0 load code, 1 amplitude, 2 step, 3 absolute angle, 4 period, 5 prescaler, 6 interrupt enable (bit 0), 32..63 table entries 0..31. At a reload, a load code with bit 15 clear loads amplitude, step, period and prescaler, and the absolute-angle register has no effect. A load code with bit 15 set (0x8001) also replaces the accumulator with the absolute angle, and no step is added that period.
- R9: A reload window is the first period after reset and then every P periods, where P is the active prescaler and 0 counts as 1. A load code written outside a window waits for the next window. Values loaded in a window, including the step and the prescaler, apply from that same period.
- R10: At a reload the load code clears, so `load_pending` falls. `irq` pulses for one cycle only if interrupt enable bit 0 is set.
- R11: With table entry i = round(32767·(1 + (π/64)²/16)·cos(iπ/64)), the interpolated cosine stays within 7 LSB of 32767·cos. Observed through T = 65535 and Ampl = 65535, each high-time is within 9 ticks of 32767.5·(1 + cos).
- R12: Writes to the shadow registers do not change the outputs until a reload window takes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_tick | input | 1 | Start-of-PWM-period strobe |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 6 | Host register word address |
| wr_data | input | 32 | Host write data |
| load_pending | output | 1 | Load code is non-zero |
| irq | output | 1 | One-cycle reload interrupt |
| angle_out | output | 32 | Current vector angle |
| ht_valid | output | 1 | High-times updated this cycle |
| ht_a | output | 16 | Phase A high-time in ticks |
| ht_b | output | 16 | Phase B high-time in ticks |
| ht_c | output | 16 | Phase C high-time in ticks |

## Verification
The assertions assume that host writes and period ticks never land on the same edge as the ADVANCE state. A write there races the reload sample, and the bound checks on the high-times and the counter then no longer describe a single reload. The stimulus issues every write at a falling edge, and only between computations, so each write is settled before the next tick arrives. Extra ticks are injected only during the cosine states, where the state machine must discard them.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADVANCE,
        ST_COS_A,
        ST_COS_B,
        ST_SCALE
    } sdc_state_e;

    localparam int unsigned REG_LOAD   = 0;
    localparam int unsigned REG_AMPL   = 1;
    localparam int unsigned REG_STEP   = 2;
    localparam int unsigned REG_ANGLE  = 3;
    localparam int unsigned REG_PERIOD = 4;
    localparam int unsigned REG_PRESC  = 5;
    localparam int unsigned REG_IRQEN  = 6;

    localparam int unsigned LOAD_ANGLE_BIT = 15;

endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
    import sdc_pkg::*;
#(
    parameter int ANGLE_W      = 32,
    parameter int DATA_W       = 16,
    parameter int TBL_AW       = 5,
    parameter int RESET_PERIOD = 1000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [TBL_AW:0]                  wr_addr,
    input  logic [ANGLE_W-1:0]               wr_data,
    input  logic                             clr_load,
    output logic [DATA_W-1:0]                load_code,
    output logic [DATA_W-1:0]                ampl_sh,
    output logic [ANGLE_W-1:0]               step_sh,
    output logic [ANGLE_W-1:0]               angle_sh,
    output logic [DATA_W-1:0]                per_sh,
    output logic [DATA_W-1:0]                presc_sh,
    output logic                             irq_en,
    output logic [(2**TBL_AW)-1:0][DATA_W-1:0] tbl
);

    localparam int TBL_N = 2 ** TBL_AW;

    logic [TBL_AW-1:0] reg_sel;
    logic sel_tbl, sel_load, sel_ampl, sel_step, sel_angle, sel_per, sel_presc, sel_irq;

    always_comb begin
        reg_sel   = wr_addr[TBL_AW-1:0];
        sel_tbl   = wr_en &&  wr_addr[TBL_AW];
        sel_load  = wr_en && !wr_addr[TBL_AW] && (reg_sel == TBL_AW'(REG_LOAD));
        sel_ampl  = wr_en && !wr_addr[TBL_AW] && (reg_sel == TBL_AW'(REG_AMPL));
        sel_step  = wr_en && !wr_addr[TBL_AW] && (reg_sel == TBL_AW'(REG_STEP));
        sel_angle = wr_en && !wr_addr[TBL_AW] && (reg_sel == TBL_AW'(REG_ANGLE));
        sel_per   = wr_en && !wr_addr[TBL_AW] && (reg_sel == TBL_AW'(REG_PERIOD));
        sel_presc = wr_en && !wr_addr[TBL_AW] && (reg_sel == TBL_AW'(REG_PRESC));
        sel_irq   = wr_en && !wr_addr[TBL_AW] && (reg_sel == TBL_AW'(REG_IRQEN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_code <= '0;
            ampl_sh   <= '0;
            step_sh   <= '0;
            angle_sh  <= '0;
            per_sh    <= DATA_W'(RESET_PERIOD);
            presc_sh  <= DATA_W'(1);
            irq_en    <= 1'b0;
            for (int i = 0; i < TBL_N; i++) begin
                tbl[i] <= '0;
            end
        end else begin
            // the reload clears the code; a host write in the same cycle wins
            if (clr_load)  load_code <= '0;
            if (sel_load)  load_code <= wr_data[DATA_W-1:0];
            if (sel_ampl)  ampl_sh   <= wr_data[DATA_W-1:0];
            if (sel_step)  step_sh   <= wr_data;
            if (sel_angle) angle_sh  <= wr_data;
            if (sel_per)   per_sh    <= wr_data[DATA_W-1:0];
            if (sel_presc) presc_sh  <= wr_data[DATA_W-1:0];
            if (sel_irq)   irq_en    <= wr_data[0];
            if (sel_tbl)   tbl[reg_sel] <= wr_data[DATA_W-1:0];
        end
    end

    // R10: a reload leaves the load code at zero unless the host rewrote it
    a_r10_load_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_load) && !$past(sel_load)) |-> (load_code == '0));

endmodule

// File: rtl/sdc_cosine.sv
module sdc_cosine #(
    parameter int ANGLE_W = 32,
    parameter int DATA_W  = 16,
    parameter int TBL_AW  = 5
) (
    input  logic [ANGLE_W-1:0]                 angle,
    input  logic [(2**TBL_AW)-1:0][DATA_W-1:0] tbl,
    output logic signed [DATA_W+1:0]           value
);

    localparam int TBL_N = 2 ** TBL_AW;
    localparam int QW    = ANGLE_W - 2;       // position bits inside a quadrant
    localparam int SW    = DATA_W + 2;        // signed sample width
    localparam int PW    = SW + DATA_W + 1;   // interpolation product width

    logic [1:0]              quad;
    logic [QW:0]             x;
    logic [TBL_AW-1:0]       idx;
    logic [TBL_AW-1:0]       idx_nx;
    logic [DATA_W-1:0]       frac;
    logic signed [SW-1:0]    t0, t1, diff, mag;
    logic signed [PW-1:0]    prod, acc;

    always_comb begin
        quad   = angle[ANGLE_W-1 -: 2];
        // odd quadrants run the quarter wave backwards
        x      = quad[0] ? ({1'b1, {QW{1'b0}}} - {1'b0, angle[QW-1:0]})
                         : {1'b0, angle[QW-1:0]};
        idx    = x[QW-1 -: TBL_AW];
        idx_nx = idx + 1'b1;
        frac   = x[QW-1-TBL_AW -: DATA_W];
        t0     = $signed({2'b00, tbl[idx]});
        t1     = (idx == TBL_AW'(TBL_N-1)) ? '0 : $signed({2'b00, tbl[idx_nx]});
        diff   = t1 - t0;
        prod   = diff * $signed({1'b0, frac});
        acc    = (prod >>> DATA_W) + {{(PW-SW){t0[SW-1]}}, t0};
        mag    = x[QW] ? '0 : acc[SW-1:0];
        // negative half of the cosine: quadrants 1 and 2
        value  = (quad[1] ^ quad[0]) ? -mag : mag;
    end

endmodule

// File: rtl/sdc_scale.sv
module sdc_scale #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]        ampl,
    input  logic [DATA_W-1:0]        period,
    input  logic signed [DATA_W+1:0] s,
    output logic [DATA_W-1:0]        ht
);

    localparam int SW = DATA_W + 2;
    localparam int MW = DATA_W + SW + 1;       // amplitude product width
    localparam int RW = DATA_W + MW + 1;       // period product width
    localparam logic signed [MW-1:0] HALF = MW'(1) <<< (DATA_W - 1);

    logic signed [MW-1:0] m, u;
    logic signed [RW-1:0] r, raw, per_ext;

    always_comb begin
        m       = $signed({1'b0, ampl}) * s;
        u       = (m >>> DATA_W) + HALF;
        per_ext = RW'($signed({1'b0, period}));
        r       = $signed({1'b0, period}) * u;
        raw     = r >>> DATA_W;
        if (raw < 0)
            ht = '0;
        else if (raw > per_ext)
            ht = period;
        else
            ht = raw[DATA_W-1:0];
    end

endmodule

// File: rtl/sine_duty_calc.sv
module sine_duty_calc
    import sdc_pkg::*;
#(
    parameter int ANGLE_W      = 32,
    parameter int DATA_W       = 16,
    parameter int TBL_AW       = 5,
    parameter int RESET_PERIOD = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               period_tick,
    input  logic               wr_en,
    input  logic [TBL_AW:0]    wr_addr,
    input  logic [ANGLE_W-1:0] wr_data,
    output logic               load_pending,
    output logic               irq,
    output logic [ANGLE_W-1:0] angle_out,
    output logic               ht_valid,
    output logic [DATA_W-1:0]  ht_a,
    output logic [DATA_W-1:0]  ht_b,
    output logic [DATA_W-1:0]  ht_c
);

    localparam int TBL_N = 2 ** TBL_AW;
    localparam int SW    = DATA_W + 2;
    localparam int NPH   = 3;
    // 120 degrees on an even-width angle circle
    localparam logic [ANGLE_W-1:0] THIRD = {(ANGLE_W/2){2'b01}};

    sdc_state_e state_q, state_d;

    logic [DATA_W-1:0]               load_code, ampl_sh, per_sh, presc_sh;
    logic [ANGLE_W-1:0]              step_sh, angle_sh;
    logic                            irq_en;
    logic [TBL_N-1:0][DATA_W-1:0]    tbl;

    logic [DATA_W-1:0]               ampl_act, per_act, presc_act, cnt_q;
    logic [ANGLE_W-1:0]              step_act, angle_q, cos_angle;
    logic signed [SW-1:0]            sa_q, sb_q, cos_val;
    logic signed [SW-1:0]            s_ph    [NPH];
    logic [DATA_W-1:0]               ht_calc [NPH];
    logic [DATA_W-1:0]               ht_q    [NPH];
    logic                            ht_valid_q, irq_q;
    logic                            window, take, take_angle;
    logic [DATA_W-1:0]               cnt_from_sh, cnt_from_act;

    sdc_regs #(
        .ANGLE_W(ANGLE_W), .DATA_W(DATA_W), .TBL_AW(TBL_AW), .RESET_PERIOD(RESET_PERIOD)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clr_load (take),
        .load_code(load_code),
        .ampl_sh  (ampl_sh),
        .step_sh  (step_sh),
        .angle_sh (angle_sh),
        .per_sh   (per_sh),
        .presc_sh (presc_sh),
        .irq_en   (irq_en),
        .tbl      (tbl)
    );

    // one shared evaluator serves both phases in consecutive states
    assign cos_angle = (state_q == ST_COS_B) ? (angle_q - THIRD) : angle_q;

    sdc_cosine #(
        .ANGLE_W(ANGLE_W), .DATA_W(DATA_W), .TBL_AW(TBL_AW)
    ) u_cos (
        .angle(cos_angle),
        .tbl  (tbl),
        .value(cos_val)
    );

    assign s_ph[0] = sa_q;
    assign s_ph[1] = sb_q;
    assign s_ph[2] = -(sa_q + sb_q);

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        sdc_scale #(.DATA_W(DATA_W)) u_scale (
            .ampl  (ampl_act),
            .period(per_act),
            .s     (s_ph[g]),
            .ht    (ht_calc[g])
        );
    end

    // reload window and load decode
    always_comb begin
        window       = (cnt_q == '0);
        take         = (state_q == ST_ADVANCE) && window && (load_code != '0);
        take_angle   = take && load_code[LOAD_ANGLE_BIT];
        cnt_from_sh  = (presc_sh  == '0) ? '0 : presc_sh  - 1'b1;
        cnt_from_act = (presc_act == '0) ? '0 : presc_act - 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (period_tick) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = ST_COS_A;
            ST_COS_A:   state_d = ST_COS_B;
            ST_COS_B:   state_d = ST_SCALE;
            ST_SCALE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ampl_act   <= '0;
            step_act   <= '0;
            per_act    <= DATA_W'(RESET_PERIOD);
            presc_act  <= DATA_W'(1);
            cnt_q      <= '0;
            angle_q    <= '0;
            sa_q       <= '0;
            sb_q       <= '0;
            ht_valid_q <= 1'b0;
            irq_q      <= 1'b0;
            for (int i = 0; i < NPH; i++) ht_q[i] <= '0;
        end else begin
            ht_valid_q <= 1'b0;
            irq_q      <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_ADVANCE: begin
                    if (take) begin
                        ampl_act  <= ampl_sh;
                        step_act  <= step_sh;
                        per_act   <= per_sh;
                        presc_act <= presc_sh;
                        cnt_q     <= cnt_from_sh;
                        angle_q   <= take_angle ? angle_sh : angle_q + step_sh;
                        irq_q     <= irq_en;
                    end else begin
                        angle_q   <= angle_q + step_act;
                        cnt_q     <= window ? cnt_from_act : cnt_q - 1'b1;
                    end
                end
                ST_COS_A: sa_q <= cos_val;
                ST_COS_B: sb_q <= cos_val;
                ST_SCALE: begin
                    for (int i = 0; i < NPH; i++) ht_q[i] <= ht_calc[i];
                    ht_valid_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign load_pending = (load_code != '0);
    assign irq          = irq_q;
    assign angle_out    = angle_q;
    assign ht_valid     = ht_valid_q;
    assign ht_a         = ht_q[0];
    assign ht_b         = ht_q[1];
    assign ht_c         = ht_q[2];

    // R2: one valid pulse per computation
    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        ht_valid_q |=> !ht_valid_q);

    // R6: published high-times never exceed the active period
    a_r6_ht_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ht_valid_q |-> ((ht_q[0] <= per_act) && (ht_q[1] <= per_act) && (ht_q[2] <= per_act)));

    // R10: an interrupt needs the enable and a reload decision one cycle earlier
    a_r10_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(irq_en) && $past(state_q == ST_ADVANCE)));

    // R9: the window counter stays below the active prescaler
    a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) || (cnt_q < presc_act));

endmodule

// File: tb/sine_duty_calc_test.sv
module sine_duty_calc_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] THIRD = 32'h5555_5555;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        period_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        load_pending, irq, ht_valid;
    logic [31:0] angle_out;
    logic [15:0] ht_a, ht_b, ht_c;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    longint tblm [32];
    longint sh_ampl, sh_step, sh_angle, sh_per, sh_presc, sh_load, sh_irqen;
    longint m_ampl, m_step, m_per, m_presc, m_cnt;
    logic [31:0] m_angle;

    always #(CLK_PERIOD/2) clk = ~clk;

    sine_duty_calc uut (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_pending(load_pending), .irq(irq), .angle_out(angle_out),
        .ht_valid(ht_valid), .ht_a(ht_a), .ht_b(ht_b), .ht_c(ht_c)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint cosm(input logic [31:0] a);
        longint p, x, i, fr, t0, t1, acc;
        p = longint'(a[29:0]);
        x = a[30] ? ((64'sd1 <<< 30) - p) : p;
        if (x == (64'sd1 <<< 30)) acc = 0;
        else begin
            i  = x >>> 25;
            fr = (x >>> 9) & 65535;
            t0 = tblm[i];
            t1 = (i == 31) ? 0 : tblm[i+1];
            acc = t0 + (((t1 - t0) * fr) >>> 16);
        end
        if (a[31] ^ a[30]) acc = -acc;
        return acc;
    endfunction

    function automatic longint htm(input longint ampl, input longint t, input longint s);
        longint q, u, r;
        q = (ampl * s) >>> 16;
        u = q + 32768;
        r = (t * u) >>> 16;
        if (r < 0) r = 0;
        if (r > t) r = t;
        return r;
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        case (addr)
            0: sh_load  = longint'(data[15:0]);
            1: sh_ampl  = longint'(data[15:0]);
            2: sh_step  = longint'(data);
            3: sh_angle = longint'(data);
            4: sh_per   = longint'(data[15:0]);
            5: sh_presc = longint'(data[15:0]);
            6: sh_irqen = longint'(data[0]);
            default: ;
        endcase
    endtask

    task automatic run_period(input bit extra_tick);
        bit window;
        longint irq_exp, irqs, sa, sb, sc;
        window = (m_cnt == 0);
        irq_exp = 0;
        if (window && sh_load != 0) begin
            m_ampl = sh_ampl; m_step = sh_step; m_per = sh_per; m_presc = sh_presc;
            if (sh_load[15]) m_angle = sh_angle[31:0];
            else             m_angle = m_angle + sh_step[31:0];
            m_cnt = (m_presc == 0) ? 0 : m_presc - 1;
            irq_exp = sh_irqen;
            sh_load = 0;
        end else begin
            m_angle = m_angle + m_step[31:0];
            m_cnt = window ? ((m_presc == 0) ? 0 : m_presc - 1) : m_cnt - 1;
        end
        sa = cosm(m_angle);
        sb = cosm(m_angle - THIRD);
        sc = -(sa + sb);

        @(negedge clk) period_tick = 1'b1;
        @(negedge clk) period_tick = 1'b0;
        irqs = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (extra_tick && k == 0) period_tick = 1'b1;
            if (extra_tick && k == 1) period_tick = 1'b0;
            irqs += irq;
            if (k == 2) chk("R2 valid low before result", ht_valid, 0);
        end
        @(negedge clk);
        irqs += irq;
        chk("R2 valid at 4th edge", ht_valid, 1);
        chk("R5/R6 ht_a", ht_a, htm(m_ampl, m_per, sa));
        chk("R5/R6 ht_b", ht_b, htm(m_ampl, m_per, sb));
        chk("R5/R6 ht_c", ht_c, htm(m_ampl, m_per, sc));
        chk("R3 angle", angle_out, longint'(m_angle));
        @(negedge clk);
        irqs += irq;
        chk("R2 valid one cycle", ht_valid, 0);
        chk("R10 irq pulses", irqs, irq_exp);
        chk("R10 load pending", load_pending, (sh_load != 0) ? 1 : 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int unsigned seed;
        real tv, kk;
        seed = $urandom(32'd4242);
        sh_ampl = 0; sh_step = 0; sh_angle = 0; sh_per = 1000; sh_presc = 1;
        sh_load = 0; sh_irqen = 0;
        m_ampl = 0; m_step = 0; m_per = 1000; m_presc = 1; m_cnt = 0; m_angle = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ht_a", ht_a, 0);
        chk("R1 ht_b", ht_b, 0);
        chk("R1 ht_c", ht_c, 0);
        chk("R1 valid", ht_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pending", load_pending, 0);
        chk("R1 angle", angle_out, 0);

        // table for R11 accuracy
        kk = 1.0 + (3.14159265358979 / 64.0) ** 2 / 16.0;
        for (int i = 0; i < 32; i++) begin
            tv = 32767.0 * kk * $cos(i * 3.14159265358979 / 64.0);
            tblm[i] = longint'($rtoi(tv + 0.5));
            wr(32 + i, 32'(tblm[i]));
        end

        // R7: zero amplitude before first reload, R12: shadows inert
        wr(1, 32'd30000);
        run_period(0);
        chk("R7 half period", ht_a, 500);

        // first reload with interrupt
        wr(6, 32'd1);
        wr(1, 32'd20000); wr(2, 32'h0100_0000); wr(4, 32'd2000); wr(5, 32'd1);
        wr(0, 32'h0001);
        run_period(0);
        run_period(0);

        // R6 clamps: absolute angle 0 and 180 degrees at full amplitude
        wr(1, 32'd65535); wr(2, 32'd0); wr(3, 32'h0000_0000); wr(0, 32'h8001);
        run_period(0);
        chk("R6 clamp high", ht_a, 2000);
        wr(3, 32'h8000_0000); wr(0, 32'h8001);
        run_period(0);
        chk("R6 clamp low", ht_a, 0);
        // R4 quadrant boundaries
        wr(3, 32'h4000_0000); wr(0, 32'h8001); run_period(0);
        wr(3, 32'hC000_0000); wr(0, 32'h8001); run_period(0);
        wr(3, 32'h3FFF_FFFF); wr(0, 32'h8001); run_period(0);

        // R8: angle register ignored with plain load code
        wr(2, 32'h0123_4567); wr(3, 32'h7777_0000); wr(0, 32'h0001);
        run_period(0);
        chk("R8 angle register ignored", angle_out, longint'(m_angle));

        // R10: interrupt disabled, load still cleared
        wr(6, 32'd0); wr(1, 32'd12345); wr(0, 32'h0001);
        run_period(0);

        // R9: prescaler 3, request outside the window waits
        wr(6, 32'd1); wr(5, 32'd3); wr(0, 32'h0001);
        run_period(0);
        wr(1, 32'd40000); wr(0, 32'h0001);
        run_period(0);
        chk("R9 request waits", load_pending, 1);
        run_period(0);
        run_period(0);

        // R2: extra ticks during computation ignored
        run_period(1);
        run_period(1);

        // random mix
        for (int n = 0; n < 220; n++) begin
            if ($urandom_range(0, 3) == 0) wr(1, 32'($urandom_range(0, 65535)));
            if ($urandom_range(0, 3) == 0) wr(2, $urandom());
            if ($urandom_range(0, 5) == 0) wr(3, $urandom());
            if ($urandom_range(0, 5) == 0) wr(4, 32'($urandom_range(16, 65535)));
            if ($urandom_range(0, 5) == 0) wr(5, 32'($urandom_range(0, 3)));
            if ($urandom_range(0, 7) == 0) wr(6, 32'($urandom_range(0, 1)));
            case ($urandom_range(0, 3))
                0: wr(0, 32'h0001);
                1: wr(0, 32'h8001);
                default: ;
            endcase
            run_period($urandom_range(0, 7) == 0);
        end

        // R11 accuracy sweep at full scale
        wr(6, 32'd0); wr(5, 32'd1); wr(4, 32'd65535); wr(1, 32'd65535); wr(2, 32'd0);
        wr(0, 32'h0001); run_period(0);
        run_period(0);
        for (int j = 0; j < 64; j++) begin
            logic [31:0] a;
            real ideal;
            longint dev;
            a = 32'(j) * 32'h0400_0000 + 32'h0012_3457;
            wr(3, a); wr(0, 32'h8001);
            run_period(0);
            ideal = 32767.5 * (1.0 + $cos(3.14159265358979 * ($itor(a) / 2147483648.0)));
            dev = longint'($rtoi(($itor(ht_a) - ideal) * (($itor(ht_a) > ideal) ? 1.0 : -1.0)));
            checks++;
            if (dev > 9) begin
                errors++;
                $display("FAIL R11 accuracy actual=%0d expected=%0d", ht_a, longint'($rtoi(ideal)));
            end
        end

        finish_run();
    end

endmodule